// File: doc/BRIEF.md
# Protected Main Clock Prescaler

This block divides the main clock into a single clock-enable pulse train. That one enable is shared by the processor and the peripheral clock domains, so the two always run at the same rate. The division ratio and the main clock source choice sit in registers that ordinary bus writes cannot change. Software first writes a magic key to a key register. A protected register write is then accepted only during a short count of cycles that follows.

A sticky lock bit can freeze both control registers and the lock register itself until the next hardware reset. At reset, the lock bit is loaded from a fuse input. A rejected protected write leaves the target register unchanged and raises a sticky violation flag, which software can read. A new ratio is picked up only when the divider counter wraps, so no enable interval is ever cut short.

Top module: `clk_prot_prescaler`

## Requirements
- R1: Address map: 0 = key (write) / status (read), 1 = source select, 2 = divider control, 3 = lock. Writing 0xD8 to address 0 opens the unlock window. Writes to addresses 1, 2 and 3 are accepted only while the window is open and the lock is clear.
- R2: The window stays open for WIN_CYCLES (default 4) clock edges after the edge that takes the key. A protected write on the 4th following edge is accepted. A protected write on the 5th following edge is rejected.
- R3: The window closes after the first accepted protected write. A write to address 0 with a value other than the key, made while the window is open, leaves it open.
- R4: A rejected protected write leaves the register unchanged and sets status bit 1 (violation). Only reset clears that bit.
- R5: Once lock bit 0 at address 3 reads 1, writes to addresses 1, 2 and 3 are all rejected until reset, even inside an open window.
- R6: During reset, the lock bit takes the value of fuse_lock_i.
- R7: After reset, the divider control reads 0x11 (enable = 1, code = 8, divide by 6), the source select reads 0, status reads 0, and clk_en_o pulses once every 6 cycles.
- R8: The divider control register holds the enable in bit 0 and a 4-bit code in bits 4:1. Codes 0,1,2,3,4,5 divide by 2,4,8,16,32,64. Codes 8,9,10,11,12 divide by 6,10,12,24,48. All other codes divide by 2. When the enable is 0, clk_en_o is high on every cycle.
- R9: A new ratio takes effect only at the counter wrap. The interval that is running when the write lands keeps its old length.
- R10: Reads are registered. rd_data_o shows the register selected by rd_addr_i one clock edge later. An accepted source-select write appears on main_src_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst | input | 1 | Synchronous active-high reset |
| fuse_lock_i | input | 1 | Fuse value loaded into the lock bit at reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 2 | Write register address |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read register address |
| rd_data_o | output | 8 | Registered read data |
| main_src_o | output | SRC_W | Selected main clock source |
| clk_en_o | output | 1 | Divided clock enable shared by the processor and peripheral domains |

## Verification
The bench builds the block with its defaults: WIN_CYCLES = 4 and SRC_W = 2. With a four-cycle window, both the last accepted edge and the first rejected edge can be placed exactly by idle-cycle counts. The largest ratio, 64, keeps every measured gap between enable pulses short enough to walk the whole code table. Fuse loading is covered by holding the fuse high across a reset and showing that an otherwise valid keyed write is refused.

// File: rtl/prot_clk_pkg.sv
package prot_clk_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;
  localparam int CODE_W = 4;
  localparam int DIV_W  = 7;
  localparam logic [DATA_W-1:0] UNLOCK_KEY = 8'hD8;
  localparam logic [ADDR_W-1:0] A_KEY  = 2'd0;
  localparam logic [ADDR_W-1:0] A_SRC  = 2'd1;
  localparam logic [ADDR_W-1:0] A_DIV  = 2'd2;
  localparam logic [ADDR_W-1:0] A_LOCK = 2'd3;
  localparam logic [CODE_W:0]   DIVCTL_RESET = 5'h11;

  function automatic logic [DIV_W-1:0] div_ratio(input logic [CODE_W-1:0] code, input logic pen);
    logic [DIV_W-1:0] r;
    if (!pen) return DIV_W'(1);
    case (code)
      4'd0:    r = DIV_W'(2);
      4'd1:    r = DIV_W'(4);
      4'd2:    r = DIV_W'(8);
      4'd3:    r = DIV_W'(16);
      4'd4:    r = DIV_W'(32);
      4'd5:    r = DIV_W'(64);
      4'd8:    r = DIV_W'(6);
      4'd9:    r = DIV_W'(10);
      4'd10:   r = DIV_W'(12);
      4'd11:   r = DIV_W'(24);
      4'd12:   r = DIV_W'(48);
      default: r = DIV_W'(2);
    endcase
    return r;
  endfunction
endpackage

// File: rtl/unlock_window.sv
module unlock_window #(
  parameter int WIN_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic key_hit_i,
  input  logic prot_ok_i,
  output logic open_o
);
  localparam int CW = $clog2(WIN_CYCLES + 1);
  logic [CW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)            left_q <= '0;
    else if (key_hit_i) left_q <= CW'(WIN_CYCLES);
    else if (prot_ok_i) left_q <= '0;
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign open_o = (left_q != '0);

  // R2: the remaining count never exceeds the window length
  a_r2_window_bound: assert property (@(posedge clk) disable iff (rst)
    left_q <= CW'(WIN_CYCLES));
  // R3: an accepted protected write closes the window
  a_r3_close_on_write: assert property (@(posedge clk) disable iff (rst)
    (prot_ok_i && !key_hit_i) |=> !open_o);
endmodule

// File: rtl/prot_div_counter.sv
module prot_div_counter
  import prot_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] target_i,
  output logic             en_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cur_q;
  logic             wrap;

  assign wrap = (cnt_q == cur_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      cur_q <= DIV_W'(6);
      en_o  <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      cur_q <= target_i;
      en_o  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      en_o  <= 1'b0;
    end
  end

  // R9: the active ratio changes only at the wrap point
  a_r9_ratio_held: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(cur_q));
  // R8: divide-by-1 gives an enable on every cycle
  a_r8_div1_every: assert property (@(posedge clk) disable iff (rst)
    (cur_q == DIV_W'(1)) |=> en_o);
endmodule

// File: rtl/clk_prot_prescaler.sv
module clk_prot_prescaler
  import prot_clk_pkg::*;
#(
  parameter int WIN_CYCLES = 4,
  parameter int SRC_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fuse_lock_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [1:0]        rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic [SRC_W-1:0]  main_src_o,
  output logic              clk_en_o
);
  logic             key_hit, prot_req, prot_ok, win_open;
  logic [SRC_W-1:0] src_q;
  logic [CODE_W:0]  divctl_q;
  logic             lock_q, viol_q;
  logic [DATA_W-1:0] rd_next;

  assign key_hit  = wr_en_i && (wr_addr_i == A_KEY) && (wr_data_i == UNLOCK_KEY);
  assign prot_req = wr_en_i && (wr_addr_i != A_KEY);
  assign prot_ok  = prot_req && win_open && !lock_q;

  unlock_window #(.WIN_CYCLES(WIN_CYCLES)) i_window (
    .clk(clk), .rst(rst), .key_hit_i(key_hit), .prot_ok_i(prot_ok), .open_o(win_open)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q    <= '0;
      divctl_q <= DIVCTL_RESET;
      lock_q   <= fuse_lock_i;
      viol_q   <= 1'b0;
    end else begin
      if (prot_ok) begin
        case (wr_addr_i)
          A_SRC:   src_q    <= wr_data_i[SRC_W-1:0];
          A_DIV:   divctl_q <= wr_data_i[CODE_W:0];
          A_LOCK:  lock_q   <= wr_data_i[0];
          default: ;
        endcase
      end
      if (prot_req && !prot_ok) viol_q <= 1'b1;
    end
  end

  prot_div_counter i_div (
    .clk(clk), .rst(rst),
    .target_i(div_ratio(divctl_q[CODE_W:1], divctl_q[0])),
    .en_o(clk_en_o)
  );

  always_comb begin
    rd_next = '0;
    case (rd_addr_i)
      A_KEY:   begin rd_next[0] = win_open; rd_next[1] = viol_q; end
      A_SRC:   rd_next[SRC_W-1:0] = src_q;
      A_DIV:   rd_next[CODE_W:0]  = divctl_q;
      default: rd_next[0] = lock_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data_o <= '0;
    else     rd_data_o <= rd_next;
  end

  assign main_src_o = src_q;

  // R5: lock is sticky until reset
  a_r5_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);
  // R5: locked control registers do not move
  a_r5_frozen: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> ($stable(divctl_q) && $stable(src_q)));
  // R4: violation flag is sticky
  a_r4_viol_sticky: assert property (@(posedge clk) disable iff (rst)
    viol_q |=> viol_q);
  // R1: with the window closed the divider control holds
  a_r1_closed_hold: assert property (@(posedge clk) disable iff (rst)
    !win_open |=> $stable(divctl_q));
endmodule

// File: tb/test_clk_prot_prescaler.sv
module test_clk_prot_prescaler;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fuse_lock_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [1:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;
  logic [1:0] main_src_o;
  logic       clk_en_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] rv;
  int gap;

  // {pen, code, expected ratio}
  localparam logic [11:0] VEC [14] = '{
    {1'b1, 4'd0,  7'd2},  {1'b1, 4'd1,  7'd4},  {1'b1, 4'd2,  7'd8},
    {1'b1, 4'd3,  7'd16}, {1'b1, 4'd4,  7'd32}, {1'b1, 4'd5,  7'd64},
    {1'b1, 4'd8,  7'd6},  {1'b1, 4'd9,  7'd10}, {1'b1, 4'd10, 7'd12},
    {1'b1, 4'd11, 7'd24}, {1'b1, 4'd12, 7'd48}, {1'b1, 4'd6,  7'd2},
    {1'b1, 4'd15, 7'd2},  {1'b0, 4'd5,  7'd1}
  };

  always #2 clk = ~clk;

  clk_prot_prescaler i_clk_prot_prescaler (
    .clk(clk), .rst(rst), .fuse_lock_i(fuse_lock_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .main_src_o(main_src_o), .clk_en_o(clk_en_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    rd_addr_i = a;
    @(negedge clk);
    d = rd_data_o;
  endtask

  task automatic wait_pulse();
    do @(negedge clk); while (!clk_en_o);
  endtask

  task automatic measure(output int g);
    wait_pulse();
    g = 0;
    do begin @(negedge clk); g++; end while (!clk_en_o);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R7 reset state
    rd(2'd2, rv); check("R7 divctl reset", rv, 8'h11);
    rd(2'd1, rv); check("R7 src reset", rv, 0);
    rd(2'd0, rv); check("R7 status reset", rv, 0);
    rd(2'd3, rv); check("R6 lock from fuse=0", rv, 0);
    measure(gap); check("R7 reset ratio", gap, 6);

    // R8 code table walked by one loop
    for (int i = 0; i < 14; i++) begin
      wr(2'd0, 8'hD8);
      wr(2'd2, {3'b0, VEC[i][10:7], VEC[i][11]});
      wait_pulse(); wait_pulse();
      measure(gap);
      check($sformatf("R8 code %0d pen %0d", VEC[i][10:7], VEC[i][11]), gap, int'(VEC[i][6:0]));
    end

    // R9 interval in flight keeps old length
    wr(2'd0, 8'hD8); wr(2'd2, 8'h07);     // code 3 -> 16
    wait_pulse(); wait_pulse();
    gap = 0;
    wr(2'd0, 8'hD8); gap++;
    wr(2'd2, 8'h01); gap++;                // code 0 -> 2
    while (!clk_en_o) begin @(negedge clk); gap++; end
    check("R9 old interval not shortened", gap, 16);
    measure(gap); check("R9 new ratio after wrap", gap, 2);

    // R10 source select and read path
    wr(2'd0, 8'hD8); wr(2'd1, 8'h02);
    rd(2'd1, rv); check("R10 src readback", rv, 2);
    check("R10 main_src_o", main_src_o, 2);

    // R1 / R4 write without key
    wr(2'd2, 8'h03);
    rd(2'd2, rv); check("R1 unkeyed write ignored", rv, 8'h01);
    rd(2'd0, rv); check("R4 violation set", rv[1], 1);

    // R2 last edge accepted, next rejected
    do_reset();
    wr(2'd0, 8'hD8); idle(3); wr(2'd2, 8'h05);
    rd(2'd2, rv); check("R2 4th edge accepted", rv, 8'h05);
    rd(2'd0, rv); check("R2 no violation", rv[1], 0);
    wr(2'd0, 8'hD8); idle(4); wr(2'd2, 8'h07);
    rd(2'd2, rv); check("R2 5th edge rejected", rv, 8'h05);
    rd(2'd0, rv); check("R4 violation after expiry", rv[1], 1);
    idle(3);
    rd(2'd0, rv); check("R4 violation sticky", rv[1], 1);

    // R3 non-key write keeps window; first protected write closes it
    do_reset();
    wr(2'd0, 8'hD8); wr(2'd0, 8'h00); wr(2'd2, 8'h09);
    rd(2'd2, rv); check("R3 window survives plain write", rv, 8'h09);
    wr(2'd0, 8'hD8); wr(2'd2, 8'h0B); wr(2'd2, 8'h0D);
    rd(2'd2, rv); check("R3 second write rejected", rv, 8'h0B);

    // R5 lock
    do_reset();
    wr(2'd0, 8'hD8); wr(2'd3, 8'h01);
    rd(2'd3, rv); check("R5 lock set", rv, 1);
    wr(2'd0, 8'hD8); wr(2'd2, 8'h03);
    rd(2'd2, rv); check("R5 divctl frozen", rv, 8'h11);
    wr(2'd0, 8'hD8); wr(2'd1, 8'h01);
    rd(2'd1, rv); check("R5 src frozen", rv, 0);
    wr(2'd0, 8'hD8); wr(2'd3, 8'h00);
    rd(2'd3, rv); check("R5 lock not clearable", rv, 1);
    measure(gap); check("R5 ratio unchanged", gap, 6);

    // R6 fuse loads lock
    fuse_lock_i = 1'b1;
    do_reset();
    fuse_lock_i = 1'b0;
    rd(2'd3, rv); check("R6 lock from fuse=1", rv, 1);
    wr(2'd0, 8'hD8); wr(2'd2, 8'h01);
    rd(2'd2, rv); check("R6 fused lock blocks write", rv, 8'h11);
    do_reset();
    rd(2'd3, rv); check("R6 reset clears lock with fuse=0", rv, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule